// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is the device side of a byte-wide flash memory. It watches the write strobes on a simple synchronous bus. It recognises the multi-write unlock and command sequences and runs byte program, sector erase or whole-array erase on a small internal array.

While an operation is running, the ready output is low. A read during that time returns a status byte instead of array data. Bit 7 of that byte is the inverse of bit 7 of the value being written. Bit 6 flips on every read. When the operation finishes, reads return true array data again.

Any write that breaks a sequence sends the interpreter back to read mode. A command-reset input does the same and also abandons a running operation. Operation lengths are parameters given in clock cycles. The array is kept small: its depth is a parameter, and the sector number comes from the upper bits of the array index.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After rst_n is released, ready is 1, rdata is 00h and every array byte reads FFh.
- R2: The four writes AAh@5555h, 55h@2AAAh, A0h@5555h, then D@A start a program of D at array index A[7:0].
- R3: Programming only clears bits: the stored byte becomes old AND D.
- R4: The six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 30h@A set the 8 bytes of sector A[7:3] to FFh. All other bytes are left unchanged.
- R5: The same prefix followed by 10h@5555h sets every byte to FFh, and ready is low for CERASE_CYC cycles.
- R6: A write that does not match the next step of a sequence returns the interpreter to read mode and leaves the array unchanged. A correct sequence written after it still works.
- R7: A read while busy returns a status byte. Bit 7 is the inverse of bit 7 of the target data (target data is FFh for erases), and bits 5..0 are 0.
- R8: Status bit 6 is 0 on the first read after an operation starts and inverts on each further read while busy.
- R9: ready falls on the clock edge that takes the final command write. For a program it rises exactly PROG_CYC edges later, when the new data becomes readable.
- R10: A one-cycle cmd_rst abandons a running operation, so ready is 1 at the next edge and the array is unchanged. It also discards a partially written sequence.
- R11: Writes made while busy are ignored and do not count toward a new sequence.
- R12: rdata is loaded on the edge where rd_en is 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; array set to FFh |
| cmd_rst | input | 1 | Synchronous return to read mode, aborts operation |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe, one cycle per read |
| addr | input | ADDR_W | Bus address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or status, registered |
| ready | output | 1 | 1 when no operation is running |

## Verification
Read data and status appear on rdata one edge after the strobe. A driver task puts each expected byte into a queue, and a monitor compares it on the falling edge after the sampling edge. The ready line is checked on falling edges relative to the final command write. It is checked low straight after that write, still low after the operation length minus one further cycles, and high one cycle later. That brackets the exact edge on which the operation completes. Status reads are issued while the operation is known to be running. Ignored writes and aborts are checked one falling edge later through ready, followed by reads of the bytes they could have changed.

// File: rtl/fcsm_pkg.sv
package fcsm_pkg;
   typedef enum logic [2:0] {
      SQ_READ, SQ_UNL1, SQ_UNL2, SQ_PGM, SQ_ERS0, SQ_ERS1, SQ_ERS2
   } seq_t;

   typedef enum logic [1:0] {
      OP_NONE, OP_PROG, OP_SERASE, OP_CERASE
   } op_t;

   localparam logic [7:0] CD_KEY1  = 8'hAA;
   localparam logic [7:0] CD_KEY2  = 8'h55;
   localparam logic [7:0] CD_PROG  = 8'hA0;
   localparam logic [7:0] CD_ERASE = 8'h80;
   localparam logic [7:0] CD_SECT  = 8'h30;
   localparam logic [7:0] CD_CHIP  = 8'h10;
endpackage

// File: rtl/fcsm_seq.sv
module fcsm_seq
   import fcsm_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int IDX_W  = 8,
   parameter logic [ADDR_W-1:0] KEY_A1 = 16'h5555,
   parameter logic [ADDR_W-1:0] KEY_A2 = 16'h2AAA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              busy,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic              launch,
   output op_t               launch_kind,
   output op_t               op_kind,
   output logic [IDX_W-1:0]  op_idx,
   output logic [7:0]        op_data
);
   seq_t st, nxt;

   always_comb begin
      nxt         = st;
      launch      = 1'b0;
      launch_kind = OP_NONE;
      if (clr) begin
         nxt = SQ_READ;
      end else if (wr_en && !busy) begin
         nxt = SQ_READ;
         unique case (st)
            SQ_READ: if (wdata == CD_KEY1 && addr == KEY_A1) nxt = SQ_UNL1;
            SQ_UNL1: if (wdata == CD_KEY2 && addr == KEY_A2) nxt = SQ_UNL2;
            SQ_UNL2: begin
               if (wdata == CD_PROG && addr == KEY_A1)       nxt = SQ_PGM;
               else if (wdata == CD_ERASE && addr == KEY_A1) nxt = SQ_ERS0;
            end
            SQ_PGM: begin
               launch      = 1'b1;
               launch_kind = OP_PROG;
            end
            SQ_ERS0: if (wdata == CD_KEY1 && addr == KEY_A1) nxt = SQ_ERS1;
            SQ_ERS1: if (wdata == CD_KEY2 && addr == KEY_A2) nxt = SQ_ERS2;
            SQ_ERS2: begin
               if (wdata == CD_SECT) begin
                  launch      = 1'b1;
                  launch_kind = OP_SERASE;
               end else if (wdata == CD_CHIP && addr == KEY_A1) begin
                  launch      = 1'b1;
                  launch_kind = OP_CERASE;
               end
            end
            default: nxt = SQ_READ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= SQ_READ;
         op_kind <= OP_NONE;
         op_idx  <= '0;
         op_data <= 8'hFF;
      end else begin
         st <= nxt;
         if (launch) begin
            op_kind <= launch_kind;
            op_idx  <= addr[IDX_W-1:0];
            op_data <= (launch_kind == OP_PROG) ? wdata : 8'hFF;
         end
      end
   end

   p_clr_to_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (st == SQ_READ));
   p_launch_ends_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (st == SQ_READ));
   p_busy_writes_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy && !clr) |=> $stable(st));
endmodule

// File: rtl/fcsm_timer.sv
module fcsm_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len,
   input  logic             abort,
   output logic             busy,
   output logic             done
);
   logic [CNT_W-1:0] cnt;

   assign done = busy && (cnt == '0) && !abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (abort) begin
         busy <= 1'b0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= len - 1'b1;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   p_start_sets_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !abort) |=> busy);
   p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy);
   p_busy_needs_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

// File: rtl/fcsm_array.sv
module fcsm_array
   import fcsm_pkg::*;
#(
   parameter int DEPTH   = 256,
   parameter int SECTORS = 32,
   parameter int IDX_W   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             apply,
   input  op_t              kind,
   input  logic [IDX_W-1:0] op_idx,
   input  logic [7:0]       op_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_byte
);
   localparam int SEC_W  = $clog2(SECTORS);
   localparam int SEC_SZ = DEPTH / SECTORS;

   if (DEPTH % SECTORS != 0) begin : g_bad_split
      $error("DEPTH must be a multiple of SECTORS");
   end
   if ((1 << SEC_W) != SECTORS || SECTORS < 2) begin : g_bad_sec
      $error("SECTORS must be a power of two, at least 2");
   end

   logic [7:0] cells [DEPTH];
   logic [SEC_W-1:0] op_sec;
   logic [7:0]       old_byte;

   assign op_sec   = op_idx[IDX_W-1 -: SEC_W];
   assign old_byte = cells[op_idx];
   assign rd_byte  = cells[rd_idx];

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      localparam logic [SEC_W-1:0] MY_SEC = SEC_W'(g / SEC_SZ);
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= 8'hFF;
         end else if (apply) begin
            unique case (kind)
               OP_PROG:   if (op_idx == IDX_W'(g)) q <= q & op_data;
               OP_SERASE: if (op_sec == MY_SEC)    q <= 8'hFF;
               OP_CERASE: q <= 8'hFF;
               default:   q <= q;
            endcase
         end
      end
      assign cells[g] = q;
   end

   p_prog_only_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && kind == OP_PROG) |=>
         ((cells[$past(op_idx)] & ~$past(old_byte)) == 8'h00));
   p_chip_all_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && kind == OP_CERASE) |=>
         (cells[0] == 8'hFF && cells[DEPTH-1] == 8'hFF));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import fcsm_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DEPTH      = 256,
   parameter int SECTORS    = 32,
   parameter int PROG_CYC   = 8,
   parameter int SERASE_CYC = 20,
   parameter int CERASE_CYC = 40,
   parameter logic [ADDR_W-1:0] KEY_A1 = 16'h5555,
   parameter logic [ADDR_W-1:0] KEY_A2 = 16'h2AAA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              ready
);
   localparam int IDX_W  = $clog2(DEPTH);
   localparam int MAX_AB = (PROG_CYC > SERASE_CYC) ? PROG_CYC : SERASE_CYC;
   localparam int MAX_C  = (MAX_AB > CERASE_CYC) ? MAX_AB : CERASE_CYC;
   localparam int CNT_W  = $clog2(MAX_C + 1);

   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("ADDR_W too narrow for DEPTH");
   end
   if (PROG_CYC < 1 || SERASE_CYC < 1 || CERASE_CYC < 1) begin : g_bad_cyc
      $error("operation lengths must be at least one cycle");
   end

   logic             launch, busy, done, tog;
   op_t              launch_kind, op_kind;
   logic [IDX_W-1:0] op_idx;
   logic [7:0]       op_data, arr_byte;
   logic [CNT_W-1:0] len;

   fcsm_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .KEY_A1(KEY_A1), .KEY_A2(KEY_A2)) u_seq (
      .clk(clk), .rst_n(rst_n), .clr(cmd_rst), .busy(busy), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .launch(launch), .launch_kind(launch_kind),
      .op_kind(op_kind), .op_idx(op_idx), .op_data(op_data)
   );

   always_comb begin
      unique case (launch_kind)
         OP_SERASE: len = CNT_W'(SERASE_CYC);
         OP_CERASE: len = CNT_W'(CERASE_CYC);
         default:   len = CNT_W'(PROG_CYC);
      endcase
   end

   fcsm_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(launch), .len(len), .abort(cmd_rst),
      .busy(busy), .done(done)
   );

   fcsm_array #(.DEPTH(DEPTH), .SECTORS(SECTORS), .IDX_W(IDX_W)) u_arr (
      .clk(clk), .rst_n(rst_n), .apply(done), .kind(op_kind), .op_idx(op_idx),
      .op_data(op_data), .rd_idx(addr[IDX_W-1:0]), .rd_byte(arr_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= 8'h00;
         tog   <= 1'b0;
      end else begin
         if (launch) tog <= 1'b0;
         else if (rd_en && busy) tog <= ~tog;
         if (rd_en) rdata <= busy ? {~op_data[7], tog, 6'b0} : arr_byte;
      end
   end

   assign ready = ~busy;

   p_toggle_flips_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy) |=> (tog != $past(tog)));
   p_ready_rise_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> ($past(done) || $past(cmd_rst)));
   p_rdata_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
endmodule

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
   localparam int PROG = 8, SERA = 20, CERA = 40;

   logic        clk = 1'b0;
   logic        rst_n, cmd_rst, wr_en, rd_en;
   logic [15:0] addr;
   logic [7:0]  wdata, rdata;
   logic        ready;

   always #2 clk = ~clk;

   flash_cmd_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cmd_rst(cmd_rst), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready)
   );

   int          n_vec = 0, n_bad = 0;
   logic [7:0]  mdl [256];
   logic [7:0]  exp_q [$];
   string       tag_q [$];
   logic        rd_q = 1'b0;

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   always @(posedge clk) rd_q <= rd_en;

   always @(negedge clk) begin
      if (rd_q) begin
         if (exp_q.size() == 0) chk("R12 unexpected read", rdata, 8'hxx);
         else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
   end

   task automatic wr(logic [15:0] a, logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [15:0] a, logic [7:0] e, string tag);
      rd_en = 1'b1; addr = a;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic unlock();
      wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
   endtask

   task automatic prog(logic [15:0] a, logic [7:0] d);
      unlock(); wr(16'h5555, 8'hA0); wr(a, d);
      mdl[a[7:0]] = mdl[a[7:0]] & d;
   endtask

   task automatic erase_pre();
      unlock(); wr(16'h5555, 8'h80); unlock();
   endtask

   task automatic wait_ready();
      for (int i = 0; i < 200 && !ready; i++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic wait_done(int n, string tag);
      chk(tag, 8'(ready), 8'd0);
      repeat (n - 1) @(negedge clk);
      chk(tag, 8'(ready), 8'd0);
      @(negedge clk);
      chk(tag, 8'(ready), 8'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
      rst_n = 1'b0; cmd_rst = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ready", 8'(ready), 8'd1);
      chk("R1 rdata", rdata, 8'h00);
      rd(16'h0010, 8'hFF, "R1 erased");
      rd(16'h00FF, 8'hFF, "R1 erased top");

      // R2 / R9 program and exact busy window
      prog(16'h0010, 8'h5A);
      wait_done(PROG, "R9 program window");
      rd(16'h0010, 8'h5A, "R2 program");

      // R3 bits only clear
      prog(16'h0010, 8'h0F);
      wait_ready();
      rd(16'h0010, 8'h0A, "R3 and");

      // R7 / R8 status during program (target bit7 = 0)
      prog(16'h0020, 8'h35);
      rd(16'h0020, 8'h80, "R7 status");
      rd(16'h0020, 8'hC0, "R8 toggle 1");
      rd(16'h0020, 8'h80, "R8 toggle 2");
      wait_ready();
      rd(16'h0020, 8'h35, "R7 true data");

      // R11 writes during busy ignored
      prog(16'h0030, 8'h00);
      unlock(); wr(16'h5555, 8'hA0);
      wait_ready();
      wr(16'h0040, 8'h00);
      chk("R11 ready", 8'(ready), 8'd1);
      rd(16'h0040, 8'hFF, "R11 untouched");
      rd(16'h0030, 8'h00, "R11 program done");

      // R6 broken sequences
      wr(16'h5555, 8'hAA); wr(16'h2AAB, 8'h55); wr(16'h5555, 8'hA0); wr(16'h0050, 8'h00);
      chk("R6 ready", 8'(ready), 8'd1);
      rd(16'h0050, 8'hFF, "R6 bad addr");
      erase_pre(); wr(16'h0010, 8'h20);
      chk("R6 ready2", 8'(ready), 8'd1);
      rd(16'h0010, 8'h0A, "R6 bad erase code");
      prog(16'h0050, 8'h77);
      wait_ready();
      rd(16'h0050, 8'h77, "R6 recovers");

      // R4 sector erase of sector 3 (indices 24..31)
      prog(16'h0018, 8'h11); wait_ready();
      prog(16'h001F, 8'h22); wait_ready();
      prog(16'h0017, 8'h44); wait_ready();
      erase_pre(); wr(16'h001A, 8'h30);
      wait_done(SERA, "R4 erase window");
      for (int i = 24; i < 32; i++) mdl[i] = 8'hFF;
      rd(16'h0018, mdl[8'h18], "R4 low end");
      rd(16'h001F, mdl[8'h1F], "R4 high end");
      rd(16'h0020, mdl[8'h20], "R4 next sector");
      rd(16'h0017, mdl[8'h17], "R4 prev sector");

      // R10 abort of chip erase, with R7/R8 erase status
      erase_pre(); wr(16'h5555, 8'h10);
      rd(16'h0000, 8'h00, "R7 erase status");
      rd(16'h0000, 8'h40, "R8 erase toggle");
      cmd_rst = 1'b1; @(negedge clk); cmd_rst = 1'b0;
      chk("R10 ready", 8'(ready), 8'd1);
      rd(16'h0020, mdl[8'h20], "R10 no erase");
      unlock();
      cmd_rst = 1'b1; @(negedge clk); cmd_rst = 1'b0;
      wr(16'h5555, 8'hA0); wr(16'h0060, 8'h00);
      chk("R10 prefix dropped", 8'(ready), 8'd1);
      rd(16'h0060, 8'hFF, "R10 no program");

      // R12 hold
      repeat (2) @(negedge clk);
      chk("R12 hold", rdata, 8'hFF);

      // R5 chip erase
      erase_pre(); wr(16'h5555, 8'h10);
      wait_done(CERA, "R5 chip window");
      rd(16'h0010, 8'hFF, "R5 erased a");
      rd(16'h0020, 8'hFF, "R5 erased b");
      rd(16'h0050, 8'hFF, "R5 erased c");
      @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule